// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an asynchronous static RAM. The RAM has an active-low chip select, an active-low write strobe and a shared data bus. The host posts one single-word read or write at a time. The controller then drives the RAM address and strobes through a fixed sequence of timed phases. It switches its own data-bus drivers on and off, and it reports completion with a one-cycle pulse that carries the read data for reads.

Every timing limit is a nanosecond parameter, together with the clock period. Each phase length is the limit divided by the clock period and rounded up, with at least one cycle.

A write lowers chip select first. The write strobe is then pulsed inside that window. The controller drives the bus only after the RAM has had time to float its outputs. Both strobes rise together to end the write, and the data stays driven for a hold phase with the chip deselected.

A read holds chip select low for the access time and samples the bus on the last edge of that phase. When a read follows a write, or a write follows a read, an extra idle cycle with the chip deselected and the bus undriven separates them.

States: `ST_IDLE` (deselected, ready), `ST_TURN` (one-cycle direction change), `ST_W_SETUP` (select low, strobe high), `ST_W_RELEASE` (strobe low, bus not yet driven), `ST_W_DRIVE` (strobe low, bus driven), `ST_W_HOLD` (both strobes high, bus still driven), `ST_R_ACCESS` (select low for the access time).

Transitions:
- `ST_IDLE` to `ST_TURN` on a request whose direction differs from the previous access.
- `ST_IDLE` to `ST_W_SETUP` or `ST_R_ACCESS` on any other request.
- `ST_TURN` to the first phase of the pending access.
- `ST_W_SETUP` to `ST_W_RELEASE` to `ST_W_DRIVE` to `ST_W_HOLD` to `ST_IDLE`.
- `ST_R_ACCESS` to `ST_IDLE`.

Each timed state leaves when its phase timer expires.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During reset and whenever `req_ready` is high, `mem_ce_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0. `req_ready` is high exactly in the idle state, including the first cycle after reset.
- R2: `mem_we_n` is low only while `mem_ce_n` is low. Chip select falls at least one cycle before the write strobe. A write is issued only for a request with `req_write`=1.
- R3: The write strobe stays low for HZ+DRV cycles. The write ends no sooner than the strobe-width, select-to-end and address-to-end limits allow.
- R4: The bus is driven only after the write strobe has been low for HZ cycles, where HZ=ceil(T_HZWE/CLK_NS). It is never driven while the RAM may drive. It is driven at least T_SD before the write ends, and it stays driven for HOLD cycles after the end with the chip deselected.
- R5: A read holds `mem_ce_n` low for ACC = max of ceil(T_RC/CLK_NS), ceil(T_AA/CLK_NS) and ceil(T_ACE/CLK_NS) cycles. The bus is sampled on the last edge of that phase. `resp_done` and `resp_rdata` appear in the first cycle after chip select rises.
- R6: A request is accepted on an edge where `req_valid` and `req_ready` are both high, and `req_ready` then drops. Each access yields exactly one single-cycle `resp_done`. For a write, `resp_done` comes HOLD+1 cycles after chip select rises.
- R7: Between two accesses of opposite direction, chip select stays high for one extra cycle beyond the same-direction gap. The same-direction gap is 1 cycle after a read and HOLD+1 cycles after a write.
- R8: A read returns the word most recently written to that address, or the RAM's prior content if the address was never written.
- R9: `mem_addr` equals the accepted address and stays stable for the whole time `mem_ce_n` is low.
- R10: Phase lengths are ceil(limit/CLK_NS) with a minimum of 1. A write holds chip select low for 1+HZ+DRV cycles, where DRV = max(ceil(T_SD/CLK_NS), PWE-HZ, WC-1-HOLD-HZ, SCE-1-HZ, AW-1-HZ, 1) and HOLD = max(1, ceil(T_HD/CLK_NS)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle, request can be accepted |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DW | Captured read data, valid with `resp_done` after a read |
| mem_addr | output | AW | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | DW | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the controller's bus drivers |
| mem_dq_in | input | DW | Data seen on the RAM bus |

## Verification
The bench runs against a behavioural RAM model. The model returns the inverted word whenever it is sampled before its access time has passed, so a controller that samples one edge early returns corrupted read data. At each write end the model measures, in nanoseconds, the strobe width, the select-to-end time, the address and data setup, and whether the bus was being driven. A design that enabled its drivers in the same cycle the strobe fell, or while the RAM still drove, would be reported as contention. Back-to-back reads and writes of opposite direction probe the turnaround cycle: a design that dropped it shows a chip-select gap one cycle short.

// File: rtl/sram_strobe_pkg.sv
`timescale 1ns/1ps
package sram_strobe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_W_SETUP,
        ST_W_RELEASE,
        ST_W_DRIVE,
        ST_W_HOLD,
        ST_R_ACCESS
    } ctrl_state_e;

    // Nanoseconds to clock cycles, rounded up, never below one.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          last
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - TW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (cap_en) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
    import sram_strobe_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 16,
    parameter int TW     = 6,
    parameter int CLK_NS = 10,
    parameter int T_RC   = 15,
    parameter int T_AA   = 15,
    parameter int T_ACE  = 15,
    parameter int T_WC   = 15,
    parameter int T_SCE  = 10,
    parameter int T_AW   = 10,
    parameter int T_PWE  = 9,
    parameter int T_SD   = 9,
    parameter int T_HD   = 0,
    parameter int T_HZWE = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          resp_done,
    output logic [DW-1:0] resp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);

    // Phase lengths in cycles
    localparam int C_ACC  = max_int(ns_to_cycles(T_RC, CLK_NS),
                                    max_int(ns_to_cycles(T_AA, CLK_NS), ns_to_cycles(T_ACE, CLK_NS)));
    localparam int C_HZ   = ns_to_cycles(T_HZWE, CLK_NS);
    localparam int C_HOLD = ns_to_cycles(T_HD, CLK_NS);
    localparam int C_DRV  = max_int(
        max_int(ns_to_cycles(T_SD, CLK_NS), ns_to_cycles(T_PWE, CLK_NS) - C_HZ),
        max_int(max_int(ns_to_cycles(T_WC, CLK_NS) - 1 - C_HOLD - C_HZ,
                        ns_to_cycles(T_SCE, CLK_NS) - 1 - C_HZ),
                max_int(ns_to_cycles(T_AW, CLK_NS) - 1 - C_HZ, 1)));

    ctrl_state_e   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          op_wr_q;
    logic          have_q;
    logic          accept;
    logic          tmr_load;
    logic          tmr_last;
    logic [TW-1:0] tmr_len;
    logic          cap_en;
    logic          ce_n_q, we_n_q, oe_q, done_q;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (have_q && (op_wr_q != req_write)) state_d = ST_TURN;
                    else if (req_write)                   state_d = ST_W_SETUP;
                    else                                  state_d = ST_R_ACCESS;
                end
            end
            ST_TURN:      if (tmr_last) state_d = op_wr_q ? ST_W_SETUP : ST_R_ACCESS;
            ST_W_SETUP:   if (tmr_last) state_d = ST_W_RELEASE;
            ST_W_RELEASE: if (tmr_last) state_d = ST_W_DRIVE;
            ST_W_DRIVE:   if (tmr_last) state_d = ST_W_HOLD;
            ST_W_HOLD:    if (tmr_last) state_d = ST_IDLE;
            ST_R_ACCESS:  if (tmr_last) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Phase length of the state being entered
    always_comb begin
        unique case (state_d)
            ST_W_RELEASE: tmr_len = TW'(C_HZ);
            ST_W_DRIVE:   tmr_len = TW'(C_DRV);
            ST_W_HOLD:    tmr_len = TW'(C_HOLD);
            ST_R_ACCESS:  tmr_len = TW'(C_ACC);
            default:      tmr_len = TW'(1);
        endcase
    end

    assign tmr_load = (state_d != state_q);
    assign cap_en   = (state_q == ST_R_ACCESS) && tmr_last;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            op_wr_q <= 1'b0;
            have_q  <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            op_wr_q <= req_write;
            have_q  <= 1'b1;
        end
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n_q <= 1'b1;
            we_n_q <= 1'b1;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            ce_n_q <= !(state_d inside {ST_W_SETUP, ST_W_RELEASE, ST_W_DRIVE, ST_R_ACCESS});
            we_n_q <= !(state_d inside {ST_W_RELEASE, ST_W_DRIVE});
            oe_q   <= (state_d inside {ST_W_DRIVE, ST_W_HOLD});
            done_q <= ((state_q == ST_W_HOLD) || (state_q == ST_R_ACCESS)) && tmr_last;
        end
    end

    sram_phase_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .last  (tmr_last)
    );

    sram_rd_capture #(.DW(DW)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (mem_dq_in),
        .dout   (resp_rdata)
    );

    assign req_ready  = (state_q == ST_IDLE);
    assign resp_done  = done_q;
    assign mem_addr   = addr_q;
    assign mem_ce_n   = ce_n_q;
    assign mem_we_n   = we_n_q;
    assign mem_dq_oe  = oe_q;
    assign mem_dq_out = wdata_q;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          resp_done,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe,
    input logic [AW-1:0] mem_addr
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

    // R2
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // R2
    ce_leads_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_ce_n));

    // R4
    drive_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_ce_n || !mem_we_n));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .resp_done (resp_done),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr)
);

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int T_RC = 15, T_AA = 15, T_ACE = 15, T_WC = 15, T_SCE = 10;
    localparam int T_AW = 10, T_PWE = 9, T_SD = 9, T_HD = 0, T_HZWE = 7;
    localparam int WATCHDOG = 150000;
    localparam int N_RANDOM = 400;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_HZ   = cyc(T_HZWE);
    localparam int E_HOLD = cyc(T_HD);
    localparam int E_ACC  = imax(cyc(T_RC), imax(cyc(T_AA), cyc(T_ACE)));
    localparam int E_DRV  = imax(imax(cyc(T_SD), cyc(T_PWE) - E_HZ),
                                 imax(imax(cyc(T_WC) - 1 - E_HOLD - E_HZ, cyc(T_SCE) - 1 - E_HZ),
                                      imax(cyc(T_AW) - 1 - E_HZ, 1)));

    function automatic logic [DW-1:0] init_word(input int a);
        return DW'(a * 40503) ^ 16'h5A3C;
    endfunction

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          req_ready, resp_done;
    logic [DW-1:0] resp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mdl_dq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_strobe_ctrl #(.AW(AW), .DW(DW)) i_sram_strobe_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .resp_done  (resp_done),
        .resp_rdata (resp_rdata),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mdl_dq)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural RAM model
    logic [DW-1:0] mdl_mem [0:(1<<AW)-1];
    logic [DW-1:0] shadow  [0:(1<<AW)-1];
    realtime t_addr = 0, t_ce_fall = 0, t_we_fall = 0, t_dq = 0;
    logic wr_on;
    assign wr_on = !mem_ce_n && !mem_we_n;

    always @(mem_addr)          t_addr    = $realtime;
    always @(negedge mem_ce_n)  t_ce_fall = $realtime;
    always @(negedge mem_we_n)  t_we_fall = $realtime;
    always @(mem_dq_out)        t_dq      = $realtime;
    always @(posedge mem_dq_oe) t_dq      = $realtime;

    always begin
        #1;
        if (!mem_ce_n && mem_we_n && (($realtime - t_addr) >= T_AA) && (($realtime - t_ce_fall) >= T_ACE))
            mdl_dq = mdl_mem[mem_addr];
        else
            mdl_dq = ~mdl_mem[mem_addr];
    end

    always @(negedge wr_on) begin
        if (rst_n) begin
            check(mem_dq_oe, "R4 bus driven at write end", 32'(mem_dq_oe), 1);
            check(($realtime - t_dq) >= T_SD, "R4 data setup ns", int'($realtime - t_dq), T_SD);
            check(($realtime - t_we_fall) >= T_PWE, "R3 WE pulse ns", int'($realtime - t_we_fall), T_PWE);
            check(($realtime - t_ce_fall) >= T_SCE, "R3 CE to write end ns", int'($realtime - t_ce_fall), T_SCE);
            check(($realtime - t_addr) >= T_AW, "R3 address to write end ns", int'($realtime - t_addr), T_AW);
            mdl_mem[mem_addr] = mem_dq_out;
        end
    end

    // Monitor
    bit            pend_valid = 0, pend_wr = 0;
    logic [AW-1:0] pend_addr = '0;
    logic [DW-1:0] pend_exp  = '0;
    bit            in_win = 0, saw_we = 0, prev_wr = 0, have_prev = 0, prev_done = 0;
    int            ce_lo = 0, we_lo = 0, oe_lo = 0, ce_hi = 0, gap = 0, hi_since_end = 0, oe_hold = 0;
    logic [AW-1:0] win_addr = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            check(mem_ce_n && mem_we_n && !mem_dq_oe && !resp_done, "R1 reset outputs",
                  {mem_ce_n, mem_we_n, mem_dq_oe, resp_done}, 4'b1100);
        end else begin
            if (!mem_ce_n) begin
                if (!in_win) begin
                    in_win = 1; gap = ce_hi; win_addr = mem_addr;
                    ce_lo = 0; we_lo = 0; oe_lo = 0; saw_we = 0;
                    check(pend_valid && (mem_addr == pend_addr), "R9 accepted address presented",
                          32'(mem_addr), 32'(pend_addr));
                end
                ce_lo++;
                if (!mem_we_n) begin we_lo++; saw_we = 1; end
                if (mem_dq_oe) oe_lo++;
                check(mem_addr == win_addr, "R9 address stable", 32'(mem_addr), 32'(win_addr));
                check(!(mem_dq_oe && (mem_we_n || (($realtime - t_we_fall) < T_HZWE))),
                      "R4 bus contention", 32'(mem_dq_oe), 0);
            end else begin
                if (in_win) begin
                    if (saw_we) begin
                        check(pend_wr, "R2 write strobe only for write", 32'(pend_wr), 1);
                        check(ce_lo == 1 + E_HZ + E_DRV, "R10 write CE-low cycles", ce_lo, 1 + E_HZ + E_DRV);
                        check(we_lo == E_HZ + E_DRV, "R3 WE-low cycles", we_lo, E_HZ + E_DRV);
                        check(oe_lo == E_DRV, "R4 drive cycles in WE pulse", oe_lo, E_DRV);
                    end else begin
                        check(!pend_wr, "R2 no write strobe for write request", 32'(pend_wr), 0);
                        check(ce_lo == E_ACC, "R5 read CE-low cycles", ce_lo, E_ACC);
                    end
                    if (have_prev)
                        check(gap >= (prev_wr ? E_HOLD : 0) + 1 + ((prev_wr != saw_we) ? 1 : 0),
                              "R7 turnaround gap", gap,
                              (prev_wr ? E_HOLD : 0) + 1 + ((prev_wr != saw_we) ? 1 : 0));
                    prev_wr = saw_we; have_prev = 1;
                    in_win = 0; ce_hi = 0; hi_since_end = 0; oe_hold = 0;
                end
                ce_hi++; hi_since_end++;
                if (mem_dq_oe) oe_hold++;
            end

            if (resp_done) begin
                check(!prev_done, "R6 done is single cycle", 32'(prev_done), 0);
                check(pend_valid, "R6 done matches an access", 32'(pend_valid), 1);
                if (pend_wr) begin
                    check(oe_hold == E_HOLD, "R4 hold drive cycles", oe_hold, E_HOLD);
                    check(hi_since_end == E_HOLD + 1, "R6 write done timing", hi_since_end, E_HOLD + 1);
                end else begin
                    check(resp_rdata == pend_exp, "R8 read data", 32'(resp_rdata), 32'(pend_exp));
                    check(hi_since_end == 1, "R5 read done timing", hi_since_end, 1);
                end
                pend_valid = 0;
            end
            prev_done = resp_done;

            if (req_ready)
                check(mem_ce_n && mem_we_n && !mem_dq_oe, "R1 idle strobes",
                      {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b110);

            if (req_valid && req_ready) begin
                pend_valid = 1; pend_wr = req_write; pend_addr = req_addr;
                if (req_write) shadow[req_addr] = req_wdata;
                else           pend_exp = shadow[req_addr];
            end
        end
    end

    // Watchdog
    int cyc_cnt = 0;
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt >= WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc_cnt, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic issue(input bit wr, input int a, input int d);
        do begin
            @(posedge clk); #1;
        end while (!req_ready);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7151));
        for (int i = 0; i < (1 << AW); i++) begin
            mdl_mem[i] = init_word(i);
            shadow[i]  = init_word(i);
        end
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1 ready after reset", 32'(req_ready), 1);

        // Directed: boundaries and every direction pairing
        issue(1'b0, 5, 0);               // R8 untouched content
        issue(1'b0, 6, 0);               // read -> read
        issue(1'b1, 0, 16'h1234);        // read -> write turnaround (R7)
        issue(1'b0, 0, 0);               // write -> read turnaround (R7)
        issue(1'b1, (1 << AW) - 1, 16'hFFFF);
        issue(1'b1, 1, 16'h0000);        // write -> write
        issue(1'b1, 2, 16'hA5A5);
        issue(1'b0, (1 << AW) - 1, 0);
        issue(1'b0, 1, 0);
        issue(1'b0, 2, 0);

        // Random mix, biased to a small address window for read-after-write hits
        for (int i = 0; i < N_RANDOM; i++) begin
            int a;
            a = ($urandom % 4 == 0) ? int'($urandom % (1 << AW)) : int'($urandom % 16);
            issue(1'($urandom % 2), a, int'($urandom % 65536));
            if ($urandom % 8 == 0) repeat (1 + $urandom % 3) @(posedge clk);
        end

        repeat (20) @(negedge clk);
        check(!pend_valid, "R6 last access completed", 32'(pend_valid), 0);
        check(req_ready && mem_ce_n, "R1 idle at end", {req_ready, mem_ce_n}, 2'b11);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule